// File: doc/BRIEF.md
# Accumulator ALU with Iterative Multiplier

This block is the arithmetic unit of a small accumulator machine. Each operation takes an accumulator operand and a buffer operand, each gated by its own enable strobe, and a 3-bit operation code. Add, subtract, the bitwise operations and the single-bit shifts finish in one clock. Multiply runs a shift-and-add loop, one multiplier bit per clock. Its 32-bit product is split into a low word, which goes back to the accumulator, and a high word, which goes to a separate multiplier-result register.

Division has no dedicated hardware. A control sequence subtracts the divisor over and over, watches the sign flag, and counts the passes in its own register. The ALU provides the wrapped difference and the sign of the registered result for that loop.

All outputs are registered. A one-cycle `done` pulse marks each new result. `busy` stays high while a multiply is in progress, and a `start` seen during that time is dropped.

Top module: `acc_alu`

## Requirements
- R1: After a synchronous active-high reset, `result`, `mr_out`, `done` and `busy` are all zero.
- R2: With `op` = 000 (ADD), `result` is the two operands summed modulo 2^16. The full code set is 000 ADD, 001 SUB, 010 MPY, 011 AND, 100 OR, 101 NOT, 110 SHL, 111 SHR.
- R3: With `op` = 001 (SUB), `result` is accumulator minus buffer modulo 2^16, and `neg` equals bit 15 of `result`.
- R4: AND (011) and OR (100) combine the two operands bitwise. NOT (101) inverts the accumulator operand.
- R5: SHL (110) shifts the accumulator operand left by one and fills bit 0 with zero. SHR (111) shifts it right by one, logically, and fills bit 15 with zero. The buffer operand has no effect on either shift.
- R6: When `acc_en` or `br_en` is low, that operand is taken as zero for every operation. For example, ADD with only `br_en` set passes `br_in` through.
- R7: MPY (010) forms the unsigned 32-bit product. The high 16 bits go to `mr_out` and the low 16 bits to `result`. For example, 700 x 100 gives `mr_out` = 0x0001 and `result` = 0x1170.
- R8: A single-cycle operation is accepted at the clock edge where `start` is high and `busy` is low, and its result and a one-cycle `done` appear right after that edge. An accepted MPY raises `busy`, and its result and `done` appear WIDTH+1 edges after the accepting edge, with `busy` falling at the same edge.
- R9: A `start` that arrives while `busy` is high is ignored. It does not raise `done` and does not change `result`.
- R10: `mr_out` changes only when a multiply completes. Every other operation leaves it as it was.
- R11: A loop of SUB operations that feeds each `result` back as the accumulator operand, and stops when `neg` is set, yields the quotient as the number of non-negative passes and the remainder as the last non-negative result. For example, 10 / 3 gives 3 remainder 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins an operation when `busy` is low |
| op | input | 3 | Operation code |
| acc_en | input | 1 | Enables the accumulator operand (zero when low) |
| br_en | input | 1 | Enables the buffer operand (zero when low) |
| acc_in | input | 16 | Accumulator operand |
| br_in | input | 16 | Buffer operand |
| result | output | 16 | Registered result word (low product word for MPY) |
| mr_out | output | 16 | High product word from the last multiply |
| neg | output | 1 | Sign of the registered result |
| done | output | 1 | One-cycle pulse when a new result is available |
| busy | output | 1 | High while a multiply is running |

## Verification
Random operands, random operation codes and random enable pairs are compared with a bench model. This exposes wrong carry or borrow handling, operand swaps in SUB, and enable gating that is applied to the wrong operand. Directed cases cover the edges. All-ones times all-ones and zero times a value test the high word of the multiply. A value with only bit 15 set and the all-ones value show the fill bit in each shift. A shift with a nonzero buffer operand shows whether that operand leaks in. A start issued while a multiply is running separates a dropped request from one that is queued or that corrupts the product. The repeated-subtraction division shows that the sign flag turns at the right pass.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_MPY = 3'b010,
    OP_AND = 3'b011,
    OP_OR  = 3'b100,
    OP_NOT = 3'b101,
    OP_SHL = 3'b110,
    OP_SHR = 3'b111
  } alu_op_e;
endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_NOT:  y = ~a;
      OP_SHL:  y = {a[W-2:0], 1'b0};
      OP_SHR:  y = {1'b0, a[W-1:1]};
      default: y = '0;
    endcase
  end

  // R5: shifts never pull a bit in at the fill end
  always_comb begin
    if (op == OP_SHL) p_shl_fill_r5: assert (y[0] == 1'b0);
    if (op == OP_SHR) p_shr_fill_r5: assert (y[W-1] == 1'b0);
  end
endmodule

// File: rtl/acc_alu_mul.sv
module acc_alu_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [2*W-1:0] prod,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  mcand;
  logic [W-1:0]  hi;
  logic [W-1:0]  lo;
  logic [CW-1:0] cnt;
  logic          active;
  logic [W:0]    sum;

  always_comb begin
    sum = lo[0] ? ({1'b0, hi} + {1'b0, mcand}) : {1'b0, hi};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand  <= '0;
      hi     <= '0;
      lo     <= '0;
      cnt    <= '0;
      active <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        mcand  <= a;
        hi     <= '0;
        lo     <= b;
        cnt    <= CW'(W);
        active <= 1'b1;
      end else if (active) begin
        hi  <= sum[W:1];
        lo  <= {sum[0], lo[W-1:1]};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  assign prod = {hi, lo};

  // R8: completion only follows an active iteration
  p_fin_after_run_r8: assert property (@(posedge clk) disable iff (rst)
    fin |-> $past(active));
  // R8: a running loop always has iterations left
  p_cnt_live_r8: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       op,
  input  logic             acc_en,
  input  logic             br_en,
  input  logic [WIDTH-1:0] acc_in,
  input  logic [WIDTH-1:0] br_in,
  output logic [WIDTH-1:0] result,
  output logic [WIDTH-1:0] mr_out,
  output logic             neg,
  output logic             done,
  output logic             busy
);
  alu_op_e            op_e;
  logic [WIDTH-1:0]   a_op;
  logic [WIDTH-1:0]   b_op;
  logic [WIDTH-1:0]   y;
  logic [2*WIDTH-1:0] prod;
  logic               mul_fin;
  logic               accept;
  logic               mul_go;

  assign op_e   = alu_op_e'(op);
  assign a_op   = acc_en ? acc_in : '0;
  assign b_op   = br_en  ? br_in  : '0;
  assign accept = start && !busy;
  assign mul_go = accept && (op_e == OP_MPY);

  acc_alu_logic #(.W(WIDTH)) u_logic (
    .op (op_e),
    .a  (a_op),
    .b  (b_op),
    .y  (y)
  );

  acc_alu_mul #(.W(WIDTH)) u_mul (
    .clk  (clk),
    .rst  (rst),
    .load (mul_go),
    .a    (a_op),
    .b    (b_op),
    .prod (prod),
    .fin  (mul_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      mr_out <= '0;
      done   <= 1'b0;
      busy   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (op_e == OP_MPY) begin
          busy <= 1'b1;
        end else begin
          result <= y;
          done   <= 1'b1;
        end
      end
      if (mul_fin) begin
        result <= prod[WIDTH-1:0];
        mr_out <= prod[2*WIDTH-1:WIDTH];
        busy   <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  assign neg = result[WIDTH-1];

  // R8: single-cycle op reports on the next cycle
  p_single_done_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && (op_e != OP_MPY)) |=> done);
  // R8: accepted multiply holds busy and does not report at once
  p_mpy_busy_r8: assert property (@(posedge clk) disable iff (rst)
    mul_go |=> (busy && !done));
  // R8: a result never shows while still busy
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: while busy, nothing but multiply completion raises done
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !mul_fin) |=> !done);
  // R10: high product word moves only on multiply completion
  p_mr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !mul_fin |=> $stable(mr_out));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic [2:0]   op;
  logic         acc_en, br_en;
  logic [W-1:0] acc_in, br_in;
  logic [W-1:0] result, mr_out;
  logic         neg, done, busy;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] mr_exp = '0;

  always #10 clk = ~clk;

  acc_alu #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .acc_en(acc_en), .br_en(br_en), .acc_in(acc_in), .br_in(br_in),
    .result(result), .mr_out(mr_out), .neg(neg), .done(done), .busy(busy)
  );

  function automatic logic [2*W-1:0] model(input logic [2:0] o,
      input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    case (o)
      3'b000: r = a + b;
      3'b001: r = a - b;
      3'b011: r = a & b;
      3'b100: r = a | b;
      3'b101: r = ~a;
      3'b110: r = a << 1;
      3'b111: r = a >> 1;
      default: r = '0;
    endcase
    if (o == 3'b010) return {16'h0, a} * {16'h0, b};
    return {16'h0, r};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
      input logic ae, input logic be, output int lat);
    @(negedge clk);
    op = o; acc_in = a; br_in = b; acc_en = ae; br_en = be; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_check(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
      input logic ae, input logic be, input string tag);
    int lat;
    logic [2*W-1:0] e;
    e = model(o, ae ? a : '0, be ? b : '0);
    issue(o, a, b, ae, be, lat);
    if (o == 3'b010) begin
      mr_exp = e[2*W-1:W];
      chk(lat == W + 2, {tag, " R8 mpy latency"}, lat, W + 2);
    end else begin
      chk(lat == 1, {tag, " R8 latency"}, lat, 1);
    end
    chk(result == e[W-1:0], {tag, " result"}, result, e[W-1:0]);
    chk(mr_out == mr_exp, {tag, " R10 mr_out"}, mr_out, mr_exp);
    chk(neg == e[W-1], {tag, " R3 neg"}, neg, e[W-1]);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    int q;
    logic [W-1:0] acc;
    logic [2:0] ro;
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; op = '0; acc_en = 1'b0; br_en = 1'b0;
    acc_in = '0; br_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(result == 0 && mr_out == 0 && !done && !busy, "R1 reset state",
        {result, mr_out, done, busy}, 0);

    run_check(3'b000, 16'hFFFF, 16'h0002, 1, 1, "R2 add wrap");
    run_check(3'b001, 16'h0003, 16'h0005, 1, 1, "R3 sub borrow");
    run_check(3'b011, 16'hF0F0, 16'h3C3C, 1, 1, "R4 and");
    run_check(3'b100, 16'hF0F0, 16'h0F01, 1, 1, "R4 or");
    run_check(3'b101, 16'h1234, 16'hFFFF, 1, 1, "R4 not");
    run_check(3'b110, 16'h8001, 16'hFFFF, 1, 1, "R5 shl");
    run_check(3'b111, 16'hFFFF, 16'hFFFF, 1, 1, "R5 shr");
    run_check(3'b000, 16'h1111, 16'hBEEF, 0, 1, "R6 br pass");
    run_check(3'b001, 16'h1234, 16'h5555, 1, 0, "R6 acc only");
    run_check(3'b010, 16'd700, 16'd100, 1, 1, "R7 mpy 700x100");
    chk(mr_out == 16'h0001 && result == 16'h1170, "R7 split", {mr_out, result}, 32'h00011170);
    run_check(3'b010, 16'hFFFF, 16'hFFFF, 1, 1, "R7 mpy max");
    run_check(3'b010, 16'h0000, 16'h1234, 1, 1, "R7 mpy zero");
    run_check(3'b000, 16'h0001, 16'h0001, 1, 1, "R10 hold after add");

    // R9: start during multiply is dropped
    @(negedge clk);
    op = 3'b010; acc_in = 16'd300; br_in = 16'd300; acc_en = 1; br_en = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after mpy", busy, 1);
    @(negedge clk);
    op = 3'b000; acc_in = 16'h0001; br_in = 16'h0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R9 ignored start no done", done, 0);
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk(result == 16'h5F90 && mr_out == 16'h0001, "R9 product intact",
        {mr_out, result}, 32'h00015F90);
    mr_exp = 16'h0001;
    @(negedge clk);
    chk(done == 1'b0 && result == 16'h5F90, "R9 no late op", {done, result}, 16'h5F90);

    // R11: division by repeated subtraction
    acc = 16'd10; q = 0;
    for (int i = 0; i < 20; i++) begin
      issue(3'b001, acc, 16'd3, 1, 1, lat);
      if (neg) break;
      acc = result;
      q++;
    end
    chk(q == 3, "R11 quotient", q, 3);
    chk(acc == 16'd1, "R11 remainder", acc, 1);

    // random mix
    for (int i = 0; i < 300; i++) begin
      ro = 3'($urandom_range(0, 7));
      run_check(ro, 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), "rand R2-R7 mix");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule